// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins an A side and a B side with two 18-bit data lanes, one for each direction. Each lane has a storage stage that can work in three ways. It can pass its input straight through. It can keep a value it captured earlier. It can take a new value when its lane clock rises, but only while that lane's active-low clock enable is low. Each lane also has its own active-low output enable. On the A side and on the B side, the bidirectional pad is split into three signals: an input bus, an output bus and a drive-enable output. The high-impedance state is shown by the drive-enable being low. A bus-hold keeper on each input bus stands in for an undriven bus: while the external driver flag is low, the keeper supplies the last value that was actually driven.

The block runs on one system clock with a synchronous reset. Each lane clock is an ordinary input, sampled on the system clock. A rising lane-clock edge is detected when the lane clock reads high in the current sample and read low in the sample before. Each cycle, each lane decides on one of three actions:
- FLOW: the latch enable is high.
- LOAD: the latch enable is low, a lane-clock rise is seen and the clock enable is low.
- KEEP: every other case.

The transitions between actions follow directly from the input conditions. FLOW moves to KEEP when the latch enable falls. KEEP moves to LOAD on a qualified edge, and LOAD returns to KEEP on the next cycle. Any action moves to FLOW when the latch enable rises.

Top module: `xcvr_universal`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals the effective A data in the same cycle. While `ba_le` is 1, `a_out` equals the effective B data in the same cycle.
- R2: When a latch enable falls with its lane clock low, the lane output keeps the last value that passed through in the final cycle of transparency.
- R3: While a latch enable stays 0 and no qualified lane-clock rise is seen, the lane output does not change, whatever its data input does.
- R4: With the latch enable at 0, a lane clock that reads 1 after reading 0, with the clock enable at 0, loads the effective input at that system-clock edge. The output shows the loaded value from the next cycle on.
- R5: With the clock enable at 1, lane-clock rises load nothing and the output keeps its value.
- R6: `b_oe` is 1 exactly when `ab_oe_n` is 0, and `a_oe` is 1 exactly when `ba_oe_n` is 0. The output data value does not depend on the output enable.
- R7: The B-to-A lane behaves exactly like the A-to-B lane, using `ba_le`, `ba_clk`, `ba_clken_n` and `ba_oe_n`.
- R8: The two lanes store independently, so each can hold a different value at the same time.
- R9: While a driver flag (`a_drv` or `b_drv`) is 0, the effective data on that side is the last value that was sampled while the flag was 1.
- R10: Synchronous reset clears both stored values and both keepers to zero.
- R11: A lane clock held high loads only once. A further load needs the lane clock to read 0 and then 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving on the A side |
| a_drv | input | 1 | 1 while an external driver is active on the A side |
| a_out | output | 18 | Data the block drives onto the A side |
| a_oe | output | 1 | A-side drive enable (0 models high impedance) |
| b_in | input | 18 | Data arriving on the B side |
| b_drv | input | 1 | 1 while an external driver is active on the B side |
| b_out | output | 18 | Data the block drives onto the B side |
| b_oe | output | 1 | B-side drive enable (0 models high impedance) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, active high |
| ab_clk | input | 1 | A-to-B lane clock (sampled) |
| ab_clken_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, active high |
| ba_clk | input | 1 | B-to-A lane clock (sampled) |
| ba_clken_n | input | 1 | B-to-A clock enable, active low |

## Verification
The bench walks both lanes through transparent, held and clocked operation at the same time, using different values in each lane. A design that shared storage between the lanes, or dropped the value when the latch enable fell, would show the wrong word on one side. Several cases target the lane clock:
- A clock that stays high across several cycles must load once. A level-sensitive design would keep reloading.
- A rise with the clock enable high must be gated. A design that ignored the enable would take the new data.

Further cases switch off the driver flag during transparency, which exposes a missing keeper. Directed steps after a mid-run reset catch stored values or keeper contents that survive reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int XCVR_DW = 18;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_FLOW = 2'd1,
        ACT_LOAD = 2'd2
    } lane_act_e;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int DW = xcvr_pkg::XCVR_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] pad_in,
    input  logic          driven,
    output logic [DW-1:0] eff
);
    logic [DW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (driven) begin
            held_q <= pad_in;
        end
    end

    always_comb begin
        eff = driven ? pad_in : held_q;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int DW = XCVR_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          le,
    input  logic          lck,
    input  logic          lck_en_n,
    output logic [DW-1:0] dout
);
    lane_act_e     act;
    logic          lck_q;
    logic          lck_rise;
    logic [DW-1:0] store_q;

    assign lck_rise = lck & ~lck_q;

    // action decode: transparency wins over clocked capture
    always_comb begin
        act = ACT_KEEP;
        if (le) begin
            act = ACT_FLOW;
        end else if (lck_rise && !lck_en_n) begin
            act = ACT_LOAD;
        end
    end

    // storage register
    always_ff @(posedge clk) begin
        lck_q <= lck;
        if (rst) begin
            store_q <= '0;
        end else begin
            unique case (act)
                ACT_FLOW: store_q <= din;
                ACT_LOAD: store_q <= din;
                ACT_KEEP: store_q <= store_q;
                default:  store_q <= store_q;
            endcase
        end
    end

    // output selection
    always_comb begin
        unique case (act)
            ACT_FLOW: dout = din;
            ACT_LOAD: dout = store_q;
            ACT_KEEP: dout = store_q;
            default:  dout = store_q;
        endcase
    end
endmodule

// File: rtl/xcvr_universal.sv
module xcvr_universal #(
    parameter int DW = xcvr_pkg::XCVR_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    input  logic          a_drv,
    output logic [DW-1:0] a_out,
    output logic          a_oe,
    input  logic [DW-1:0] b_in,
    input  logic          b_drv,
    output logic [DW-1:0] b_out,
    output logic          b_oe,
    input  logic          ab_oe_n,
    input  logic          ab_le,
    input  logic          ab_clk,
    input  logic          ab_clken_n,
    input  logic          ba_oe_n,
    input  logic          ba_le,
    input  logic          ba_clk,
    input  logic          ba_clken_n
);
    logic [DW-1:0] a_eff;
    logic [DW-1:0] b_eff;

    xcvr_keeper #(.DW(DW)) u_keep_a (
        .clk(clk), .rst(rst), .pad_in(a_in), .driven(a_drv), .eff(a_eff)
    );
    xcvr_keeper #(.DW(DW)) u_keep_b (
        .clk(clk), .rst(rst), .pad_in(b_in), .driven(b_drv), .eff(b_eff)
    );

    xcvr_lane #(.DW(DW)) u_lane_ab (
        .clk(clk), .rst(rst), .din(a_eff), .le(ab_le),
        .lck(ab_clk), .lck_en_n(ab_clken_n), .dout(b_out)
    );
    xcvr_lane #(.DW(DW)) u_lane_ba (
        .clk(clk), .rst(rst), .din(b_eff), .le(ba_le),
        .lck(ba_clk), .lck_en_n(ba_clken_n), .dout(a_out)
    );

    assign b_oe = ~ab_oe_n;
    assign a_oe = ~ba_oe_n;
endmodule

// File: rtl/xcvr_universal_chk.sv
module xcvr_universal_chk #(
    parameter int DW = xcvr_pkg::XCVR_DW
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] a_in,
    input logic          a_drv,
    input logic [DW-1:0] a_out,
    input logic [DW-1:0] b_in,
    input logic          b_drv,
    input logic [DW-1:0] b_out,
    input logic          ab_le,
    input logic          ab_clk,
    input logic          ab_clken_n,
    input logic          ba_le,
    input logic          ba_clk,
    input logic          ba_clken_n
);
    a_r1_ab_flow: assert property (@(posedge clk) disable iff (rst)
        (ab_le && a_drv) |-> (b_out == a_in));

    a_r7_ba_flow: assert property (@(posedge clk) disable iff (rst)
        (ba_le && b_drv) |-> (a_out == b_in));

    a_r3_ab_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && !ab_le && $past(!ab_le)
         && !($past(ab_clk) && !$past(ab_clk, 2) && !$past(ab_clken_n)))
        |-> (b_out == $past(b_out)));

    a_r5_ba_gated: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && !ba_le && $past(!ba_le) && $past(ba_clken_n))
        |-> (a_out == $past(a_out)));

    a_r4_ab_load: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && !ab_le && $past(!ab_le) && $past(ab_clk)
         && !$past(ab_clk, 2) && !$past(ab_clken_n) && $past(a_drv))
        |-> (b_out == $past(a_in)));

    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((ab_le || b_out == '0) && (ba_le || a_out == '0)));
endmodule

bind xcvr_universal xcvr_universal_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .a_drv(a_drv), .a_out(a_out),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_clken_n(ab_clken_n),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_clken_n(ba_clken_n)
);

// File: tb/tb_xcvr_universal.sv
module tb_xcvr_universal;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 18;
    localparam int NV = 13;

    typedef struct packed {
        logic          ab_oe_n, ab_le, ab_ck, ab_cen_n, a_drv;
        logic [DW-1:0] a_d, exp_b;
        logic          exp_boe;
        logic          ba_oe_n, ba_le, ba_ck, ba_cen_n, b_drv;
        logic [DW-1:0] b_d, exp_a;
        logic          exp_aoe;
    } vec_t;

    // fields: oe_n le ck cen_n drv data expected expected_oe, per lane
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b1,18'h11111,18'h00000,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1,18'h0F0F0,18'h00000,1'b1},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,18'h2AAAA,18'h2AAAA,1'b1, 1'b0,1'b0,1'b1,1'b0,1'b1,18'h24924,18'h00000,1'b1},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,18'h15555,18'h15555,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1,18'h00007,18'h24924,1'b1},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,18'h3FFFF,18'h15555,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b1,18'h1E1E1,18'h1E1E1,1'b1},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,18'h00F0F,18'h15555,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1,18'h2FFFF,18'h1E1E1,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,18'h12345,18'h15555,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,18'h2FFFF,18'h1E1E1,1'b0},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,18'h0ABCD,18'h12345,1'b1, 1'b0,1'b0,1'b1,1'b1,1'b1,18'h3AAAA,18'h1E1E1,1'b1},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,18'h0ABCD,18'h12345,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,18'h05050,18'h1E1E1,1'b1},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,18'h33333,18'h12345,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0,18'h12121,18'h05050,1'b1},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,18'h33333,18'h12345,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1,18'h00000,18'h05050,1'b1},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,18'h33333,18'h12345,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1,18'h00000,18'h05050,1'b1},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,18'h00001,18'h33333,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1,18'h00000,18'h05050,1'b1},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,18'h3C3C3,18'h33333,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1,18'h00000,18'h05050,1'b1}
    };

    localparam string TAGS [NV] = '{
        "R10",         "R1 R8",   "R1 R7",  "R2 R7 R8", "R3 R2",
        "R3 R6",       "R4 R5",   "R11 R5", "R11 R9",   "R5 R9",
        "R6",          "R9",      "R3 R8"
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] a_in = '0, b_in = '0;
    logic          a_drv = 1'b1, b_drv = 1'b1;
    logic [DW-1:0] a_out, b_out;
    logic          a_oe, b_oe;
    logic          ab_oe_n = 1'b0, ab_le = 1'b0, ab_clk = 1'b0, ab_clken_n = 1'b0;
    logic          ba_oe_n = 1'b0, ba_le = 1'b0, ba_clk = 1'b0, ba_clken_n = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xcvr_universal #(.DW(DW)) dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_clken_n(ab_clken_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_clken_n(ba_clken_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            ab_oe_n = VECS[i].ab_oe_n; ab_le = VECS[i].ab_le; ab_clk = VECS[i].ab_ck;
            ab_clken_n = VECS[i].ab_cen_n; a_drv = VECS[i].a_drv; a_in = VECS[i].a_d;
            ba_oe_n = VECS[i].ba_oe_n; ba_le = VECS[i].ba_le; ba_clk = VECS[i].ba_ck;
            ba_clken_n = VECS[i].ba_cen_n; b_drv = VECS[i].b_drv; b_in = VECS[i].b_d;
            #1;
            chk(TAGS[i], "b_out", b_out, VECS[i].exp_b);
            chk(TAGS[i], "b_oe", {{(DW-1){1'b0}}, b_oe}, {{(DW-1){1'b0}}, VECS[i].exp_boe});
            chk(TAGS[i], "a_out", a_out, VECS[i].exp_a);
            chk(TAGS[i], "a_oe", {{(DW-1){1'b0}}, a_oe}, {{(DW-1){1'b0}}, VECS[i].exp_aoe});
            @(negedge clk);
        end

        // R10: mid-run reset clears both stores
        rst = 1'b1;
        ab_le = 1'b0; ba_le = 1'b0; ab_clk = 1'b0; ba_clk = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10", "b_out after reset", b_out, '0);
        chk("R10", "a_out after reset", a_out, '0);

        // R10 R9: keepers cleared, undriven transparent sides read zero
        a_drv = 1'b0; b_drv = 1'b0; a_in = 18'h2D2D2; b_in = 18'h1B1B1;
        ab_le = 1'b1; ba_le = 1'b1;
        #1;
        chk("R10 R9", "b_out keeper after reset", b_out, '0);
        chk("R10 R9", "a_out keeper after reset", a_out, '0);
        @(negedge clk);

        // R4 R7: clocked load on the B-to-A lane after reset
        ab_le = 1'b0; ba_le = 1'b0; b_drv = 1'b1; b_in = 18'h0C0DE; ba_clk = 1'b1;
        @(negedge clk);
        ba_clk = 1'b0; b_in = 18'h3FFFF;
        #1;
        chk("R4 R7", "a_out loaded", a_out, 18'h0C0DE);
        chk("R8", "b_out untouched", b_out, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule